// File: doc/BRIEF.md
# Sequential Unsigned Integer Divider with Selectable Algorithm

This block divides an unsigned dividend by a nonzero unsigned divisor of the same width. It returns a quotient and a remainder of that width, one quotient bit per clock. A single shift, add and subtract datapath serves two algorithms. The algorithm is picked by a mode input that is sampled when a division is accepted. In restoring mode a failed trial subtraction is undone in the same cycle. In non-restoring mode the sign of the partial remainder decides whether the next step adds or subtracts, and one correction step at the end makes the remainder non-negative.

A caller raises `start` for one cycle while `busy` is low, with the operands and the mode on the inputs. The block then runs for a fixed number of cycles and pulses `done`. The results stay on the outputs until the next division is accepted. A zero divisor is flagged and finishes at once with fixed results.

Top module: `seq_divider`

## Requirements
- R1: After reset, and after a reset applied during a division, `busy`, `done` and `div_by_zero` are low and `quotient` and `remainder` are zero.
- R2: With `mode` = 0 (restoring) and a nonzero divisor, the final `quotient` and `remainder` satisfy dividend = quotient * divisor + remainder with remainder < divisor.
- R3: With `mode` = 1 (non-restoring) and a nonzero divisor, the final `quotient` and `remainder` obey the same relation as R2.
- R4: For a nonzero divisor, `done` is high for exactly one cycle. That cycle follows the rising edge that comes WIDTH+1 edges after the edge that accepts `start`.
- R5: `busy` is high from the edge after an accepted nonzero-divisor start until `done` is raised. A `start` seen while `busy` is high is ignored and does not change the running result or its timing.
- R6: A zero divisor completes at the accepting edge: in the next cycle `done` and `div_by_zero` are high, `quotient` is all ones and `remainder` equals the dividend.
- R7: After `done`, `quotient`, `remainder` and `div_by_zero` hold their values while the operand inputs change, until the next accepted start.
- R8: An accepted start with a nonzero divisor clears `div_by_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division (accepted when not busy) |
| mode | input | 1 | 0 = restoring, 1 = non-restoring |
| dividend | input | WIDTH | Unsigned dividend |
| divisor | input | WIDTH | Unsigned divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_by_zero | output | 1 | Last division had a zero divisor |
| quotient | output | WIDTH | Quotient of the last division |
| remainder | output | WIDTH | Remainder of the last division |

## Verification
The hardest case to reach from the ports is a non-restoring run whose partial remainder is still negative after the last step, so that the final correction actually changes the remainder. The vector table includes operands whose last quotient bit is 0, such as 8/3, 100/7 and 7/9. These drive that path in non-restoring mode, and every table entry is also run in restoring mode so the two results can be compared. A second start that arrives mid-run is covered by a directed test. That test pulses `start` with different operands while `busy` is high and checks that the first result and its latency are unchanged.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;
  typedef enum logic {
    DIV_RESTORE    = 1'b0,
    DIV_NONRESTORE = 1'b1
  } div_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_addsub.sv
`timescale 1ns/1ps
// Two's complement add or subtract of equal-width operands.
module div_addsub #(
  parameter int N = 9
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         sub,
  output logic [N-1:0] res
);
  function automatic logic [N-1:0] add_or_sub(input logic [N-1:0] x,
                                               input logic [N-1:0] y,
                                               input logic         s);
    logic [N-1:0] yy;
    yy = s ? ~y : y;
    return x + yy + {{(N-1){1'b0}}, s};
  endfunction

  assign res = add_or_sub(opa, opb, sub);
endmodule

// File: rtl/div_step.sv
`timescale 1ns/1ps
// One iteration: shift A:Q left, then add or subtract M.
module div_step
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  div_mode_e        mode,
  input  logic [WIDTH:0]   a_in,
  input  logic [WIDTH-1:0] q_in,
  input  logic [WIDTH-1:0] m_in,
  output logic [WIDTH:0]   a_out,
  output logic [WIDTH-1:0] q_out,
  output logic             trial_neg
);
  localparam int AW = WIDTH + 1;

  logic [AW-1:0] shifted;
  logic [AW-1:0] m_ext;
  logic [AW-1:0] sum;
  logic          do_sub;
  logic          q_bit;

  assign shifted = {a_in[WIDTH-1:0], q_in[WIDTH-1]};
  assign m_ext   = {1'b0, m_in};
  // Restoring always subtracts; non-restoring subtracts only from a non-negative A.
  assign do_sub  = (mode == DIV_RESTORE) ? 1'b1 : ~a_in[WIDTH];

  div_addsub #(.N(AW)) u_addsub (
    .opa(shifted),
    .opb(m_ext),
    .sub(do_sub),
    .res(sum)
  );

  assign trial_neg = sum[WIDTH];
  assign q_bit     = ~trial_neg;

  always_comb begin
    if (mode == DIV_RESTORE && trial_neg) a_out = shifted;
    else                                  a_out = sum;
  end

  assign q_out = {q_in[WIDTH-2:0], q_bit};
endmodule

// File: rtl/div_ctrl.sv
`timescale 1ns/1ps
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic divisor_zero,
  output logic load,
  output logic zload,
  output logic step_en,
  output logic fix_en,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  div_state_e       state;
  logic [CNT_W-1:0] step_cnt;
  logic             accept;
  logic             last_step;

  assign accept    = start && (state == ST_IDLE);
  assign load      = accept && !divisor_zero;
  assign zload     = accept && divisor_zero;
  assign step_en   = (state == ST_RUN);
  assign fix_en    = (state == ST_FIX);
  assign busy      = (state != ST_IDLE);
  assign last_step = step_en && (step_cnt == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          step_cnt <= '0;
          if (load)  state <= ST_RUN;
          if (zload) done  <= 1'b1;
        end
        ST_RUN: begin
          step_cnt <= step_cnt + 1'b1;
          if (last_step) state <= ST_FIX;
        end
        ST_FIX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_fix_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> fix_en);
  a_r5_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r6_zero_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    zload |=> (done && !busy));
endmodule

// File: rtl/div_datapath.sv
`timescale 1ns/1ps
module div_datapath
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             zload,
  input  logic             step_en,
  input  logic             fix_en,
  input  logic             mode_in,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);
  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    a_reg;
  logic [WIDTH-1:0] q_reg;
  logic [WIDTH-1:0] m_reg;
  div_mode_e        mode_r;
  logic             dbz_r;

  logic [AW-1:0]    a_step;
  logic [WIDTH-1:0] q_step;
  logic             trial_neg;
  logic [AW-1:0]    a_fix;
  logic             need_fix;

  div_step #(.WIDTH(WIDTH)) u_step (
    .mode     (mode_r),
    .a_in     (a_reg),
    .q_in     (q_reg),
    .m_in     (m_reg),
    .a_out    (a_step),
    .q_out    (q_step),
    .trial_neg(trial_neg)
  );

  div_addsub #(.N(AW)) u_fix (
    .opa(a_reg),
    .opb({1'b0, m_reg}),
    .sub(1'b0),
    .res(a_fix)
  );

  assign need_fix = fix_en && (mode_r == DIV_NONRESTORE) && a_reg[WIDTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_reg  <= '0;
      q_reg  <= '0;
      m_reg  <= '0;
      mode_r <= DIV_RESTORE;
      dbz_r  <= 1'b0;
    end else if (load) begin
      a_reg  <= '0;
      q_reg  <= dividend;
      m_reg  <= divisor;
      mode_r <= div_mode_e'(mode_in);
      dbz_r  <= 1'b0;
    end else if (zload) begin
      a_reg  <= {1'b0, dividend};
      q_reg  <= '1;
      m_reg  <= '0;
      dbz_r  <= 1'b1;
    end else if (step_en) begin
      a_reg  <= a_step;
      q_reg  <= q_step;
    end else if (need_fix) begin
      a_reg  <= a_fix;
    end
  end

  assign quotient    = q_reg;
  assign remainder   = a_reg[WIDTH-1:0];
  assign div_by_zero = dbz_r;

  // R2: the restoring partial remainder never stays negative
  a_r2_partial_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && mode_r == DIV_RESTORE) |=> !a_reg[WIDTH]);
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |=> (a_reg < {1'b0, m_reg}));
  a_r3_fix_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |=> !a_reg[WIDTH]);
  a_r6_zero_results: assert property (@(posedge clk) disable iff (!rst_n)
    zload |=> (dbz_r && q_reg == '1 && a_reg == {1'b0, $past(dividend)}));
  a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !dbz_r);
endmodule

// File: rtl/seq_divider.sv
`timescale 1ns/1ps
module seq_divider #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             div_by_zero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  logic divisor_zero;
  logic load, zload, step_en, fix_en;

  assign divisor_zero = (divisor == '0);

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .divisor_zero(divisor_zero),
    .load        (load),
    .zload       (zload),
    .step_en     (step_en),
    .fix_en      (fix_en),
    .busy        (busy),
    .done        (done)
  );

  div_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .zload      (zload),
    .step_en    (step_en),
    .fix_en     (fix_en),
    .mode_in    (mode),
    .dividend   (dividend),
    .divisor    (divisor),
    .quotient   (quotient),
    .remainder  (remainder),
    .div_by_zero(div_by_zero)
  );

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/seq_divider_bench.sv
`timescale 1ns/1ps
module seq_divider_bench;
  localparam int W = 8;
  localparam int NV = 12;
  localparam logic [W-1:0] T_DVD [NV] = '{8'd8, 8'd100, 8'd7, 8'd255, 8'd255, 8'd0,
                                          8'd128, 8'd200, 8'd1, 8'd254, 8'd171, 8'd64};
  localparam logic [W-1:0] T_DVS [NV] = '{8'd3, 8'd7, 8'd9, 8'd1, 8'd255, 8'd5,
                                          8'd3, 8'd13, 8'd255, 8'd127, 8'd85, 8'd128};

  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  seq_divider #(.WIDTH(W)) u_seq_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .div_by_zero(div_by_zero), .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_div(input logic md, input logic [W-1:0] dd, input logic [W-1:0] ds,
                         input string req);
    int lat;
    logic [W-1:0] eq, er;
    int elat;
    if (ds == 0) begin eq = '1; er = dd; elat = 0; end
    else begin eq = dd / ds; er = dd % ds; elat = W + 1; end
    @(negedge clk); mode = md; dividend = dd; divisor = ds; start = 1;
    @(negedge clk); start = 0; lat = 0;
    if (ds != 0) chk(busy == 1'b1, "R5", "busy after start", busy, 1);
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == elat, (ds == 0) ? "R6" : "R4", "latency", lat, elat);
    chk(quotient == eq, req, "quotient", quotient, eq);
    chk(remainder == er, req, "remainder", remainder, er);
    chk(div_by_zero == (ds == 0), (ds == 0) ? "R6" : "R8", "div_by_zero",
        div_by_zero, (ds == 0));
    // R7: inputs change after done; results must hold
    dividend = ~dd; divisor = ds + 8'd1;
    @(negedge clk);
    chk(done == 1'b0, "R4", "done pulse width", done, 0);
    @(negedge clk);
    chk(quotient == eq && remainder == er, "R7", "held quotient", quotient, eq);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_chk++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    #1;
    @(negedge clk); @(negedge clk);
    chk(!busy && !done && !div_by_zero, "R1", "flags in reset", {busy, done, div_by_zero}, 0);
    chk(quotient == 0 && remainder == 0, "R1", "outputs in reset", quotient, 0);
    rst_n = 1;

    // Table walk: each vector in both modes (R2 restoring, R3 non-restoring)
    for (int i = 0; i < NV; i++) begin
      run_div(1'b0, T_DVD[i], T_DVS[i], "R2");
      run_div(1'b1, T_DVD[i], T_DVS[i], "R3");
    end

    // R6 zero divisor, then R8 flag cleared by next division
    run_div(1'b0, 8'd77, 8'd0, "R6");
    run_div(1'b1, 8'd77, 8'd0, "R6");
    run_div(1'b1, 8'd77, 8'd10, "R8");

    // R5: start during busy is ignored
    begin
      int lat;
      @(negedge clk); mode = 1; dividend = 8'd100; divisor = 8'd7; start = 1;
      @(negedge clk); start = 0; lat = 0;
      repeat (3) begin @(negedge clk); lat++; end
      dividend = 8'd50; divisor = 8'd5; mode = 0; start = 1;
      @(negedge clk); start = 0; lat++;
      while (!done && lat < 40) begin @(negedge clk); lat++; end
      chk(lat == W + 1, "R5", "latency with extra start", lat, W + 1);
      chk(quotient == 8'd14 && remainder == 8'd2, "R5", "quotient with extra start",
          quotient, 14);
      @(negedge clk);
      chk(!busy, "R5", "idle after ignored start", busy, 0);
    end

    // R1: reset during a division
    @(negedge clk); mode = 0; dividend = 8'd200; divisor = 8'd3; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(!busy && !done && quotient == 0 && remainder == 0, "R1", "reset mid-run",
        {busy, done}, 0);
    rst_n = 1;
    run_div(1'b0, 8'd200, 8'd3, "R2");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule